// File: doc/BRIEF.md
# Line-Synchronized Pixel Counter with Colour-Gain Steering

This block keeps the horizontal pixel position for an image-sensor timing generator. It runs on the master pixel clock and counts one per clock. Each time the active-low horizontal sync input falls, the count is pulled back to zero after a fixed delay, so that every line starts from the same count no matter how long the previous line ran.

The block also produces a 2-bit index that selects one of four colour-gain registers for each pixel. The index pattern restarts on the same clock edge as the count. In the mosaic mode the index alternates between two registers on every pixel. The pair in use changes from one line to the next, and a frame start re-anchors it to the first pair. A frame start is a vertical sync fall seen exactly one clock ahead of the horizontal sync fall. In the flat mode the index stays at zero.

Both sync inputs pass through a two-flop synchronizer before their falling edges are detected.

Top module: `pixel_line_sync`

## Requirements
- R1: While `rst` is high, and on the first sample after it, `pix_count` reads 0 and `gain_sel` reads 0. The line-pair state starts at the first pair.
- R2: When no count reset is due and the count is below its maximum, `pix_count` increases by exactly 1 on every rising clock edge.
- R3: With no horizontal sync, `pix_count` stops at 4095 (all ones over 12 bits) and stays there.
- R4: Call the rising edge that first samples `hd_n` low the first edge. `pix_count` reads 0 just after the eighth edge: two synchronizer stages plus six edges of delay after detection. It then counts up from 0.
- R5: A second `hd_n` fall that is detected while a count reset is still pending restarts the six-edge delay. Only the later fall produces a reset, with the same timing as R4.
- R6: In mode 0 (`mode`=0), `gain_sel` bit 1 carries the line-pair select and bit 0 carries the pixel phase. The phase is 0 on the edge where the count resets and toggles on every edge after it. On pixel n of a line the index is pair*2 + (n mod 2).
- R7: The line pair is forced to 0 (indices 0 and 1) when the horizontal sync fall is qualified. A fall is qualified when `vd_n` was first sampled low exactly one edge before `hd_n` was first sampled low.
- R8: Any other horizontal sync fall makes the line pair toggle at its count reset (0→1, 1→0). This includes a vertical sync fall two edges early.
- R9: In mode 1, `gain_sel` is 0. `mode` is sampled on each edge, so a change shows on `gain_sel` after the next rising edge. Returning to mode 0 restores the R6 pattern.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| hd_n | input | 1 | Horizontal sync, active low, asynchronous |
| vd_n | input | 1 | Vertical sync, active low, asynchronous |
| mode | input | 1 | Steering mode: 0 mosaic alternation, 1 flat index 0 |
| pix_count | output | 12 | Pixel position within the line |
| gain_sel | output | 2 | Colour-gain register index for the current pixel |

## Verification
The hardest cases to reach are the ones that depend on exact relative edge timing between the two sync inputs. These are the vertical sync fall exactly one clock ahead (which re-anchors the pair) and the fall two clocks ahead (which must not re-anchor it). The other such case is a second horizontal fall that lands inside the pending delay window.

The bench drives both syncs on falling clock edges, so the edge on which each is first sampled is known exactly. Random lines mix the three vertical sync placements, both modes and varied lengths. The bench tracks the expected pair in its own model and checks the count and index on every pixel after the reset edge. Directed sequences cover the restart window, a mode change in the middle of a line, and a 4100-clock run without sync to reach saturation.

// File: rtl/pls_pkg.sv
package pls_pkg;
    typedef enum logic {
        STEER_MOSAIC = 1'b0,
        STEER_FLAT   = 1'b1
    } steer_mode_e;
endpackage

// File: rtl/pls_sync_fall.sv
module pls_sync_fall #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sig_n_i,
    output logic fall_o
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              prev;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.chain[0] = sig_n_i;
        for (int i = 1; i < STAGES; i++) begin
            st_d.chain[i] = st_q.chain[i-1];
        end
        st_d.prev = st_q.chain[STAGES-1];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '{chain: '1, prev: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    assign fall_o = st_q.prev & ~st_q.chain[STAGES-1];
endmodule

// File: rtl/pls_reset_delay.sv
module pls_reset_delay #(
    parameter int DELAY = 6
) (
    input  logic clk,
    input  logic rst,
    input  logic fall_i,
    output logic fire_o
);
    localparam int DW = $clog2(DELAY + 1);
    localparam logic [DW-1:0] LAST = DW'(DELAY - 1);

    typedef struct packed {
        logic          pend;
        logic [DW-1:0] cnt;
    } dly_st_t;

    dly_st_t st_d, st_q;
    logic    fire;

    always_comb begin
        st_d = st_q;
        fire = 1'b0;
        if (fall_i) begin
            st_d.pend = 1'b1;
            st_d.cnt  = DW'(1);
        end else if (st_q.pend && st_q.cnt == LAST) begin
            fire      = 1'b1;
            st_d.pend = 1'b0;
            st_d.cnt  = '0;
        end else if (st_q.pend) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign fire_o = fire;

    // R5
    restart_no_fire_chk: assert property (@(posedge clk) disable iff (rst)
        fire_o |-> !$past(fall_i));

    // R4
    fire_needs_pending_chk: assert property (@(posedge clk) disable iff (rst)
        $past(fall_i) |-> st_q.pend);
endmodule

// File: rtl/pls_pixel_counter.sv
module pls_pixel_counter #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fire_i,
    output logic [CNT_W-1:0] count_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [CNT_W-1:0] count;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (fire_i) begin
            st_d.count = '0;
        end else if (st_q.count != CNT_MAX) begin
            st_d.count = st_q.count + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count_o = st_q.count;
endmodule

// File: rtl/pls_gain_steer.sv
module pls_gain_steer
    import pls_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        hd_fall_i,
    input  logic        vd_fall_i,
    input  logic        fire_i,
    input  steer_mode_e mode_i,
    output logic [1:0]  gain_o
);
    typedef struct packed {
        logic       vdf;
        logic       qual;
        logic       pair;
        logic       phase;
        logic [1:0] gain;
    } steer_st_t;

    steer_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.vdf = vd_fall_i;
        if (hd_fall_i) begin
            st_d.qual = st_q.vdf;
        end
        if (fire_i) begin
            st_d.pair  = st_q.qual ? 1'b0 : ~st_q.pair;
            st_d.phase = 1'b0;
        end else begin
            st_d.phase = ~st_q.phase;
        end
        st_d.gain = (mode_i == STEER_FLAT) ? 2'b00 : {st_d.pair, st_d.phase};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign gain_o = st_q.gain;

    // R7
    pair_anchor_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(fire_i) && $past(st_q.qual) && $past(mode_i) == STEER_MOSAIC)
        |-> gain_o == 2'b00);
endmodule

// File: rtl/pixel_line_sync.sv
module pixel_line_sync
    import pls_pkg::*;
#(
    parameter int CNT_W       = 12,
    parameter int SYNC_STAGES = 2,
    parameter int RESET_DELAY = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hd_n,
    input  logic             vd_n,
    input  logic             mode,
    output logic [CNT_W-1:0] pix_count,
    output logic [1:0]       gain_sel
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic        hd_fall;
    logic        vd_fall;
    logic        fire;
    steer_mode_e steer_mode;

    assign steer_mode = steer_mode_e'(mode);

    pls_sync_fall #(.STAGES(SYNC_STAGES)) u_hd_sync (
        .clk(clk), .rst(rst), .sig_n_i(hd_n), .fall_o(hd_fall)
    );

    pls_sync_fall #(.STAGES(SYNC_STAGES)) u_vd_sync (
        .clk(clk), .rst(rst), .sig_n_i(vd_n), .fall_o(vd_fall)
    );

    pls_reset_delay #(.DELAY(RESET_DELAY)) u_delay (
        .clk(clk), .rst(rst), .fall_i(hd_fall), .fire_o(fire)
    );

    pls_pixel_counter #(.CNT_W(CNT_W)) u_count (
        .clk(clk), .rst(rst), .fire_i(fire), .count_o(pix_count)
    );

    pls_gain_steer u_steer (
        .clk(clk), .rst(rst), .hd_fall_i(hd_fall), .vd_fall_i(vd_fall),
        .fire_i(fire), .mode_i(steer_mode), .gain_o(gain_sel)
    );

    logic [1:0] alive_q;
    always_ff @(posedge clk) begin
        if (rst) begin
            alive_q <= '0;
        end else if (alive_q != 2'd3) begin
            alive_q <= alive_q + 1'b1;
        end
    end

    // R1
    reset_zero_chk: assert property (@(posedge clk)
        $past(rst) |-> (pix_count == '0 && gain_sel == 2'b00));

    // R4
    cnt_zero_after_fire_chk: assert property (@(posedge clk) disable iff (rst)
        $past(fire) |-> pix_count == '0);

    // R2
    cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
        (alive_q != 2'd0 && !$past(fire) && $past(pix_count) != CNT_MAX)
        |-> pix_count == $past(pix_count) + 1'b1);

    // R3
    cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (alive_q != 2'd0 && !$past(fire) && $past(pix_count) == CNT_MAX)
        |-> pix_count == CNT_MAX);

    // R9
    flat_mode_chk: assert property (@(posedge clk) disable iff (rst)
        (alive_q != 2'd0 && $past(mode)) |-> gain_sel == 2'b00);

    // R6
    mosaic_alt_chk: assert property (@(posedge clk) disable iff (rst)
        (alive_q == 2'd3 && !$past(mode) && !$past(mode, 2) && !$past(fire))
        |-> (gain_sel[1] == $past(gain_sel[1]) && gain_sel[0] != $past(gain_sel[0])));
endmodule

// File: tb/tb_pixel_line_sync.sv
module tb_pixel_line_sync;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        hd_n = 1'b1;
    logic        vd_n = 1'b1;
    logic        mode = 1'b0;
    logic [11:0] pix_count;
    logic [1:0]  gain_sel;

    int checks = 0;
    int errors = 0;
    int exp_pair = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    pixel_line_sync dut (
        .clk(clk), .rst(rst), .hd_n(hd_n), .vd_n(vd_n), .mode(mode),
        .pix_count(pix_count), .gain_sel(gain_sel)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int exp_gain(input int pair, input int n, input bit md);
        return md ? 0 : (pair * 2 + (n % 2));
    endfunction

    // vd_kind: 0 no VD, 1 VD one edge early (qualified), 2 VD two edges early
    task automatic do_line(input int vd_kind, input int len, input bit md);
        mode = md;
        if (vd_kind == 2) begin
            vd_n = 1'b0;
            @(negedge clk);
            @(negedge clk);
        end else if (vd_kind == 1) begin
            vd_n = 1'b0;
            @(negedge clk);
        end
        hd_n = 1'b0;
        if (vd_kind == 1) exp_pair = 0;          // R7
        else              exp_pair = 1 - exp_pair; // R8
        for (int i = 1; i <= len; i++) begin
            @(negedge clk);
            if (i == 2) begin
                hd_n = 1'b1;
                vd_n = 1'b1;
            end
            if (i >= 8) begin
                chk(i == 8 ? "R4 count zero at eighth edge" : "R2 count step",
                    int'(pix_count), i - 8);
                chk(md ? "R9 flat index" : (vd_kind == 1 ? "R7 anchored pair" :
                    (vd_kind == 2 ? "R8 early VD toggles" : "R6 mosaic index")),
                    int'(gain_sel), exp_gain(exp_pair, i - 8, md));
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        chk("R1 reset count", int'(pix_count), 0);
        chk("R1 reset index", int'(gain_sel), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R2 first count after reset", int'(pix_count), 1);
        chk("R1 phase after reset", int'(gain_sel), 1);
        repeat (4) @(negedge clk);

        // first line, no VD: pair toggles from 0 to 1
        do_line(0, 20, 1'b0);
        // qualified VD: pair back to 0
        do_line(1, 16, 1'b0);
        // VD two edges early: not qualified, toggles
        do_line(2, 16, 1'b0);
        // flat mode
        do_line(0, 14, 1'b1);

        // R5: restart of pending delay
        mode = 1'b0;
        hd_n = 1'b0;
        @(negedge clk); @(negedge clk);
        hd_n = 1'b1;
        @(negedge clk); @(negedge clk);
        hd_n = 1'b0;
        exp_pair = 1 - exp_pair;
        for (int i = 1; i <= 12; i++) begin
            @(negedge clk);
            if (i == 2) hd_n = 1'b1;
            if (i == 4) chk("R5 no reset from first fall", int'(pix_count == 12'd0), 0);
            if (i >= 8) begin
                chk("R5 restarted reset count", int'(pix_count), i - 8);
                chk("R5 restarted index", int'(gain_sel), exp_gain(exp_pair, i - 8, 1'b0));
            end
        end

        // R9: mode change mid-line, takes effect after one edge
        mode = 1'b1;
        @(negedge clk);
        chk("R9 flat after one edge", int'(gain_sel), 0);
        mode = 1'b0;
        @(negedge clk);
        chk("R9 mosaic restored", int'(gain_sel), exp_gain(exp_pair, int'(pix_count), 1'b0));

        // random lines
        for (int k = 0; k < 40; k++) begin
            int vk;
            int ln;
            vk = int'($urandom_range(0, 2));
            ln = int'($urandom_range(10, 60));
            do_line(vk, ln, 1'($urandom_range(0, 1)));
            repeat ($urandom_range(0, 3)) @(negedge clk);
        end

        // R3: saturation without HD
        mode = 1'b0;
        repeat (4100) @(negedge clk);
        chk("R3 saturated count", int'(pix_count), 4095);
        @(negedge clk);
        chk("R3 count holds at max", int'(pix_count), 4095);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule